// File: doc/BRIEF.md
# Port Pin Interrupt Controller

This block turns the pins of one small input port into a single interrupt source. Software picks which pins take part, and which level of each pin counts as asserted. The qualified pins are ORed into one combined source. That source passes through a two-flop synchronizer into an edge detector that runs on the bus clock. A detected event sets a sticky flag. The flag raises the interrupt request when the interrupt enable is on.

Software chooses between two modes. In the edge-only mode the flag is set only when the combined source goes from deasserted to asserted. In the edge-and-level mode the flag is also set on every cycle in which the synchronized source is asserted. Software clears the flag by writing a one to an acknowledge bit.

Because the pins are ORed before detection, an edge on one pin is lost in edge-only mode while another enabled pin is already asserted. A separate wake output ignores the clock and the synchronizer. It reports any asserted enabled pin while the chip is in stop mode.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset the flag, the interrupt enable, the mode bit, all pin enables and all polarity bits are 0. Every register reads 0 and irq_o is 0.
- R2: A pin whose enable bit is 0 has no effect. Toggling it never sets the flag.
- R3: Polarity bit 0 makes low the asserted level, so a falling edge is the event. Polarity bit 1 makes high the asserted level, so a rising edge is the event. Moving a pin to its deasserted level never sets the flag.
- R4: The flag is set only when the synchronized combined source changes from deasserted to asserted. Suppose a pin change is driven between clock edges. The flag is then still 0 after the second following rising clock edge, and it reads 1 after the third.
- R5: irq_o is high exactly when the flag is 1 and the interrupt-enable bit is 1.
- R6: Writing the control register with the acknowledge bit at 1 clears the flag. Writing it with the acknowledge bit at 0 leaves the flag unchanged.
- R7: In edge-only mode (mode bit 0), an edge on one enabled pin does not set the flag while another enabled pin is asserted. A source that is held asserted does not set the flag again after an acknowledge.
- R8: While stop_i is 1, wake_o follows the combined source of the enabled, polarity-adjusted pins with no clock. While stop_i is 0, wake_o is 0.
- R9: In edge-and-level mode (mode bit 1), the flag is set while the synchronized source is asserted. An acknowledge in that state leaves the flag at 1.
- R10: When an acknowledge write and a set event fall on the same clock edge, the flag ends at 1.
- R11: Register map. Address 0 is the pin-enable register, with bits [3:0] one per pin. Address 1 is the polarity register, with bits [3:0] one per pin. Address 2 is the control register: bit 0 is the flag (read only), bit 1 is the acknowledge (write only, reads 0), bit 2 is the interrupt enable and bit 3 is the mode. Address 3 and all unused bits read 0. rdata_o is 0 while rd_en_i is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 4 | Port pin levels |
| stop_i | input | 1 | High while the chip is in stop mode |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational, 0 while no read is strobed |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Asynchronous stop-mode wake |

## Verification
The clocked properties assume that the pin levels, the stop input and the register strobes change only between clock edges. The bench meets this by driving every input just after the falling clock edge. The wake property is sampled only at clock edges. The bench therefore probes the asynchronous wake path directly between edges, changing the pins with no clock in between. Writes arrive as single-cycle strobes, so every acknowledge maps to exactly one clock edge. This lets the bench place an acknowledge on the same edge as a set event.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  // Register addresses
  localparam int unsigned ADDR_EN  = 0;
  localparam int unsigned ADDR_POL = 1;
  localparam int unsigned ADDR_CTL = 2;

  // Control register bit positions
  localparam int unsigned CTL_FLAG = 0;
  localparam int unsigned CTL_ACK  = 1;
  localparam int unsigned CTL_IE   = 2;
  localparam int unsigned CTL_MODE = 3;
  localparam int unsigned CTL_BITS = 4;

  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } det_mode_e;

  // Read image of the control register; the acknowledge position reads 0
  function automatic logic [CTL_BITS-1:0] ctl_pack(input logic flag,
                                                   input logic ie,
                                                   input logic mode);
    logic [CTL_BITS-1:0] v;
    v = '0;
    v[CTL_FLAG] = flag;
    v[CTL_IE]   = ie;
    v[CTL_MODE] = mode;
    return v;
  endfunction

endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int DW    = 8,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             flag_i,
  output logic [NPINS-1:0] en_o,
  output logic [NPINS-1:0] pol_o,
  output logic             ie_o,
  output det_mode_e        mode_o,
  output logic             ack_o,
  output logic [DW-1:0]    rdata_o
);

  function automatic logic addr_hit(input logic [AW-1:0] a, input int unsigned target);
    return a == AW'(target);
  endfunction

  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] pol_q;
  logic             ie_q;
  det_mode_e        mode_q;
  logic             wr_en_reg;
  logic             wr_pol_reg;
  logic             wr_ctl_reg;
  logic [DW-1:0]    rd_mux;
  logic             wdata_unused;

  assign wr_en_reg  = wr_en_i && addr_hit(addr_i, ADDR_EN);
  assign wr_pol_reg = wr_en_i && addr_hit(addr_i, ADDR_POL);
  assign wr_ctl_reg = wr_en_i && addr_hit(addr_i, ADDR_CTL);
  assign wdata_unused = ^wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      ie_q   <= 1'b0;
      mode_q <= MODE_EDGE;
    end else begin
      if (wr_en_reg)  en_q  <= wdata_i[NPINS-1:0];
      if (wr_pol_reg) pol_q <= wdata_i[NPINS-1:0];
      if (wr_ctl_reg) begin
        ie_q   <= wdata_i[CTL_IE];
        mode_q <= det_mode_e'(wdata_i[CTL_MODE]);
      end
    end
  end

  // Single-cycle acknowledge event, taken straight from the write strobe
  assign ack_o = wr_ctl_reg && wdata_i[CTL_ACK];

  always_comb begin
    rd_mux = '0;
    if (addr_hit(addr_i, ADDR_EN))
      rd_mux[NPINS-1:0] = en_q;
    else if (addr_hit(addr_i, ADDR_POL))
      rd_mux[NPINS-1:0] = pol_q;
    else if (addr_hit(addr_i, ADDR_CTL))
      rd_mux[CTL_BITS-1:0] = ctl_pack(flag_i, ie_q, mode_q);
  end

  assign rdata_o = rd_en_i ? rd_mux : '0;
  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign ie_o    = ie_q;
  assign mode_o  = mode_q;

endmodule

// File: rtl/pin_irq_combine.sv
module pin_irq_combine #(
  parameter int NPINS = 4
) (
  input  logic [NPINS-1:0] pins_i,
  input  logic [NPINS-1:0] en_i,
  input  logic [NPINS-1:0] pol_i,
  output logic [NPINS-1:0] hit_o,
  output logic             src_o
);

  // A pin is at its asserted level when its level matches its polarity bit
  function automatic logic pin_active(input logic level, input logic pol);
    return level == pol;
  endfunction

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign hit_o[g] = en_i[g] & pin_active(pins_i[g], pol_i[g]);
  end

  assign src_o = |hit_o;

endmodule

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      src_i,
  input  det_mode_e mode_i,
  input  logic      ack_i,
  output logic      edge_o,
  output logic      level_o,
  output logic      set_o,
  output logic      flag_o
);

  logic prev_q;
  logic flag_q;

  // The previous sample starts at the deasserted level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= src_i;
  end

  assign edge_o  = src_i & ~prev_q;
  assign level_o = (mode_i == MODE_LEVEL) & src_i;
  assign set_o   = edge_o | level_o;

  // A set event wins over an acknowledge on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (set_o) flag_q <= 1'b1;
    else if (ack_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NPINS       = 4,
  parameter int DW          = 8,
  parameter int AW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_i,
  input  logic             stop_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             irq_o,
  output logic             wake_o
);

  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] pol_q;
  logic             ie_q;
  det_mode_e        mode_q;
  logic             ack_pulse;
  logic [NPINS-1:0] pin_hits;
  logic             src_raw;
  logic             src_sync;
  logic             edge_evt;
  logic             level_evt;
  logic             set_evt;
  logic             flag_q;

  pin_irq_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .flag_i  (flag_q),
    .en_o    (en_q),
    .pol_o   (pol_q),
    .ie_o    (ie_q),
    .mode_o  (mode_q),
    .ack_o   (ack_pulse),
    .rdata_o (rdata_o)
  );

  pin_irq_combine #(.NPINS(NPINS)) comb_i (
    .pins_i (pins_i),
    .en_i   (en_q),
    .pol_i  (pol_q),
    .hit_o  (pin_hits),
    .src_o  (src_raw)
  );

  pin_irq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (src_raw),
    .q_o   (src_sync)
  );

  pin_irq_detect det_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_sync),
    .mode_i  (mode_q),
    .ack_i   (ack_pulse),
    .edge_o  (edge_evt),
    .level_o (level_evt),
    .set_o   (set_evt),
    .flag_o  (flag_q)
  );

  assign irq_o  = flag_q & ie_q;
  // Stop-mode wake takes the combined source before the synchronizer
  assign wake_o = stop_i & src_raw;

endmodule

// File: rtl/pin_irq_ctrl_chk.sv
module pin_irq_ctrl_chk
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_i,
  input logic             irq_o,
  input logic             wake_o,
  input logic [NPINS-1:0] en_q,
  input logic             ie_q,
  input det_mode_e        mode_q,
  input logic             ack_pulse,
  input logic             src_raw,
  input logic             src_sync,
  input logic             set_evt,
  input logic             flag_q
);

  assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !src_raw);

  assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt));

  assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ie_q && flag_q));

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pulse && !set_evt) |=> !flag_q);

  assert_held_no_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_EDGE) && src_sync && $past(src_sync) && !flag_q && !ack_pulse) |=> !flag_q);

  assert_wake_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_i |-> !wake_o);

  assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_LEVEL) && src_sync) |=> flag_q);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && ack_pulse) |=> flag_q);

endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NPINS(NPINS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_i    (stop_i),
  .irq_o     (irq_o),
  .wake_o    (wake_o),
  .en_q      (en_q),
  .ie_q      (ie_q),
  .mode_q    (mode_q),
  .ack_pulse (ack_pulse),
  .src_raw   (src_raw),
  .src_sync  (src_sync),
  .set_evt   (set_evt),
  .flag_q    (flag_q)
);

// File: tb/pin_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pin_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = 4'hF;
  logic       stop = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  logic       wake;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .stop_i(stop),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  // Reference model
  bit [3:0] m_en, m_pol;
  bit       m_ie, m_mode, m_flag;
  bit       hist[$];

  function automatic bit ref_source(input logic [3:0] p, input bit [3:0] e, input bit [3:0] pl);
    int hits = 0;
    for (int k = 0; k < 4; k++)
      if (e[k] && (p[k] === pl[k])) hits++;
    return hits > 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pol = 0; m_ie = 0; m_mode = 0; m_flag = 0;
      hist = '{0, 0, 0};
    end else begin
      bit raw, s_now, s_old, setv, ackv;
      raw   = ref_source(pins, m_en, m_pol);
      s_now = hist[1];
      s_old = hist[2];
      setv  = (s_now && !s_old) || (m_mode && s_now);
      ackv  = wr_en && (addr == 2'd2) && wdata[1];
      if (setv) m_flag = 1;
      else if (ackv) m_flag = 0;
      if (wr_en) begin
        case (addr)
          2'd0: m_en = wdata[3:0];
          2'd1: m_pol = wdata[3:0];
          2'd2: begin m_ie = wdata[2]; m_mode = wdata[3]; end
          default: ;
        endcase
      end
      hist.push_front(raw);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from both edges
  always @(negedge clk) begin
    #4;
    if (rst_n && !done) begin
      chk("R5 irq vs model", {7'd0, irq}, {7'd0, (m_flag && m_ie)});
      chk("R8 wake vs model", {7'd0, wake}, {7'd0, (stop && ref_source(pins, m_en, m_pol))});
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    rd_en = 1; addr = a;
    #1;
    chk(tag, rdata, exp);
    rd_en = 0;
  endtask

  task automatic set_pins(input logic [3:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    rd_chk(0, 8'h00, "R1 enable reset");
    rd_chk(1, 8'h00, "R1 polarity reset");
    rd_chk(2, 8'h00, "R1 control reset");
    chk("R1 irq reset", {7'd0, irq}, 8'h00);

    wr(0, 8'h01); wr(1, 8'h00); wr(2, 8'h04);
    rd_chk(0, 8'h01, "R11 enable readback");
    rd_chk(1, 8'h00, "R11 polarity readback");
    rd_chk(2, 8'h04, "R11 control readback");

    // Falling edge on pin0, latency check
    set_pins(4'hE);
    idle(2);
    rd_chk(2, 8'h04, "R4 flag not yet set after two edges");
    idle(1);
    rd_chk(2, 8'h05, "R4 flag set after third edge");
    chk("R5 irq high", {7'd0, irq}, 8'h01);

    wr(2, 8'h04);
    rd_chk(2, 8'h05, "R6 ack zero keeps flag");
    wr(2, 8'h06);
    rd_chk(2, 8'h04, "R6 ack one clears flag");
    idle(4);
    rd_chk(2, 8'h04, "R7 held source no re-set");

    set_pins(4'hF); idle(4);
    rd_chk(2, 8'h04, "R3 release is not an event");

    // Disabled pin toggles
    set_pins(4'hD); idle(4); set_pins(4'hF); idle(4);
    rd_chk(2, 8'h04, "R2 disabled pin ignored");

    // Masking by another asserted pin
    wr(0, 8'h03);
    set_pins(4'hE); idle(4);
    rd_chk(2, 8'h05, "R7 pin0 edge");
    wr(2, 8'h06);
    set_pins(4'hC); idle(5);
    rd_chk(2, 8'h04, "R7 pin1 edge masked by pin0");
    set_pins(4'hD); idle(4);
    rd_chk(2, 8'h04, "R7 source still asserted by pin1");
    set_pins(4'hF); idle(4);
    set_pins(4'hD); idle(4);
    rd_chk(2, 8'h05, "R7 pin1 edge after all idle");
    wr(2, 8'h06);

    // Rising polarity on pin2
    set_pins(4'hB);
    wr(1, 8'h04); wr(0, 8'h04); idle(4);
    wr(2, 8'h06);
    rd_chk(2, 8'h04, "R3 rising setup clear");
    set_pins(4'hF); idle(4);
    rd_chk(2, 8'h05, "R3 rising edge sets flag");
    wr(2, 8'h06);
    set_pins(4'hB); idle(4);
    rd_chk(2, 8'h04, "R3 falling ignored with high polarity");

    // Interrupt enable gating
    set_pins(4'hF); idle(4);
    wr(2, 8'h00);
    rd_chk(2, 8'h01, "R5 flag kept with ie off");
    chk("R5 irq gated off", {7'd0, irq}, 8'h00);
    wr(2, 8'h04);
    chk("R5 irq on again", {7'd0, irq}, 8'h01);
    wr(2, 8'h06);
    rd_chk(2, 8'h04, "R7 edge mode held source cleared");

    // Level mode
    wr(2, 8'h0C); idle(3);
    rd_chk(2, 8'h0D, "R9 level sets flag");
    wr(2, 8'h0E);
    rd_chk(2, 8'h0D, "R9 ack ignored while asserted");
    set_pins(4'hB); idle(4);
    wr(2, 8'h0E);
    rd_chk(2, 8'h0C, "R9 ack clears after release");
    wr(2, 8'h04); idle(2);

    // Acknowledge on the same edge as a set event
    set_pins(4'hF);
    @(negedge clk);
    @(negedge clk);
    wr_en = 1; addr = 2'd2; wdata = 8'h06;
    @(negedge clk);
    wr_en = 0; wdata = 0;
    rd_chk(2, 8'h05, "R10 set wins over ack");
    wr(2, 8'h06);
    rd_chk(2, 8'h04, "R10 later ack clears");

    // Stop-mode wake without clocking
    @(negedge clk);
    stop = 1;
    #1 chk("R8 wake asserted", {7'd0, wake}, 8'h01);
    pins = 4'hB;
    #1 chk("R8 wake follows pin", {7'd0, wake}, 8'h00);
    pins = 4'hF;
    #1 chk("R8 wake reasserts", {7'd0, wake}, 8'h01);
    wr(0, 8'h00);
    chk("R8 wake off with pin disabled", {7'd0, wake}, 8'h00);
    wr(0, 8'h04);
    stop = 0;
    #1 chk("R8 wake off outside stop", {7'd0, wake}, 8'h00);

    rd_chk(3, 8'h00, "R11 unused address reads zero");
    rd_en = 0; addr = 2'd0;
    #1 chk("R11 no read strobe gives zero", rdata, 8'h00);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule